// File: doc/BRIEF.md
# Modem Status Change Interrupt Logic

This block holds the modem control and status part of a receive control/status register in a serial line interface. Four status lines arrive from a data set: ring indicator, clear to send, carrier detect and secondary receive data. Each is brought into the local clock domain and passed to an edge detector. A change of interest on any line sets a sticky status-change flag. That flag raises an interrupt request when the interrupt enable bit is set.

Software uses a single register port. A write updates three output control lines and the interrupt enable bit. In the same write, setting bit 7 clears the status-change flag. The readback word is always valid. It shows the control bits, the enable bit, the flag and the four synchronised line levels. An optional strap, set as a parameter, drives a force-busy line from the request-to-send bit.

Top module: `mdm_stat_ctrl`

## Requirements
- R1: Readback bits 8, 9, 10 and 11 show the synchronised levels of ring, clear to send, carrier and secondary receive data. A level change on an input is visible there after the second rising clock edge.
- R2: A rising edge of ring sets the status-change flag (readback bit 7, also the `chg_flag` port) one clock after it is visible in readback. A falling edge of ring leaves the flag unchanged.
- R3: A rising or a falling edge of clear to send, carrier or secondary receive data sets the status-change flag, with the same latency as R2.
- R4: `irq` is high exactly when the status-change flag is 1 and the interrupt enable bit (readback bit 5) is 1.
- R5: A write loads register bits 1, 2 and 3 into `dtr`, `rts` and `sec_txd`, and bit 5 into the interrupt enable. Each output is high when its bit is 1, and the bits read back at the same positions.
- R6: With `FBUSY_STRAP` = 1, `fbusy` equals `rts`. With `FBUSY_STRAP` = 0, `fbusy` is always 0.
- R7: The flag stays set until a write with bit 7 = 1 clears it. A write with bit 7 = 0 does not change it.
- R8: When a line event and a clearing write fall in the same cycle, the flag ends up set.
- R9: Reset clears the control bits, the enable bit and the flag. Lines held high through reset do not set the flag after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_i | input | 1 | Ring indicator from the data set (asynchronous) |
| cts_i | input | 1 | Clear to send (asynchronous) |
| car_i | input | 1 | Carrier detect (asynchronous) |
| srd_i | input | 1 | Secondary receive data (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register readback |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| sec_txd | output | 1 | Secondary transmit data |
| fbusy | output | 1 | Force busy (follows rts when strapped) |
| chg_flag | output | 1 | Sticky status-change flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each line changes no more often than once every few clocks. This lets one synchronised change be tied to one event. They also assume that a write is a single-cycle strobe whose data is stable while it is high. The stimulus drives lines and writes on the falling clock edge. It moves one line at a time, with settle gaps longer than the synchronizer depth. It places a clearing write in the exact cycle of an event only in the collision test.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int REG_W     = 16;
    localparam int N_LINES   = 4;

    // readback / write bit positions
    localparam int B_DTR     = 1;
    localparam int B_RTS     = 2;
    localparam int B_STX     = 3;
    localparam int B_IE      = 5;
    localparam int B_FLAG    = 7;
    localparam int B_STAT    = 8;

    typedef enum logic [1:0] {
        LN_RING = 2'd0,
        LN_CTS  = 2'd1,
        LN_CAR  = 2'd2,
        LN_SRD  = 2'd3
    } line_e;

    // lines that raise the flag on a rising edge only
    localparam logic [N_LINES-1:0] RISE_ONLY = 4'b0001;

    typedef struct packed {
        logic dtr;
        logic rts;
        logic stx;
        logic ie;
    } ctl_t;

    function automatic ctl_t ctl_from_word(input logic [REG_W-1:0] w);
        ctl_t c;
        c.dtr = w[B_DTR];
        c.rts = w[B_RTS];
        c.stx = w[B_STX];
        c.ie  = w[B_IE];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] build_word(input ctl_t c, input logic flag,
                                                    input logic [N_LINES-1:0] st);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_DTR]  = c.dtr;
        w[B_RTS]  = c.rts;
        w[B_STX]  = c.stx;
        w[B_IE]   = c.ie;
        w[B_FLAG] = flag;
        w[B_STAT +: N_LINES] = st;
        return w;
    endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) stg[0] <= din;
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= din;
                    else     stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/mdm_edge.sv
module mdm_edge #(
    parameter int           W    = 4,
    parameter logic [W-1:0] RISE = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] raw,
    output logic [W-1:0] ev
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= raw;
        else     prev_q <= lvl;
    end

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_det
            if (RISE[g]) begin : g_rise
                assign ev[g] = lvl[g] & ~prev_q[g];
            end else begin : g_both
                assign ev[g] = lvl[g] ^ prev_q[g];
            end
        end
    endgenerate
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             set_ev,
    output ctl_t             ctl,
    output logic             flag
);
    logic clr;
    assign clr = wr & wdata[B_FLAG];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '0;
            flag <= 1'b0;
        end else begin
            if (wr) ctl <= ctl_from_word(wdata);
            flag <= set_ev | (flag & ~clr);
        end
    end

    assert_ctl_load_R5: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ctl.dtr == $past(wdata[B_DTR]) && ctl.rts == $past(wdata[B_RTS])
                && ctl.stx == $past(wdata[B_STX]) && ctl.ie == $past(wdata[B_IE])));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_ev) |=> !flag);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    assert_collide_R8: assert property (@(posedge clk) disable iff (rst)
        (set_ev && clr) |=> flag);
endmodule

// File: rtl/mdm_stat_ctrl.sv
module mdm_stat_ctrl
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit FBUSY_STRAP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ring_i,
    input  logic             cts_i,
    input  logic             car_i,
    input  logic             srd_i,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             dtr,
    output logic             rts,
    output logic             sec_txd,
    output logic             fbusy,
    output logic             chg_flag,
    output logic             irq
);
    logic [N_LINES-1:0] raw_lines, lvl, ev;
    ctl_t               ctl;
    logic               flag;

    assign raw_lines = {srd_i, car_i, cts_i, ring_i};

    mdm_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(raw_lines), .dout(lvl)
    );

    mdm_edge #(.W(N_LINES), .RISE(RISE_ONLY)) u_edge (
        .clk(clk), .rst(rst), .lvl(lvl), .raw(raw_lines), .ev(ev)
    );

    mdm_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
        .set_ev(|ev), .ctl(ctl), .flag(flag)
    );

    assign reg_rdata = build_word(ctl, flag, lvl);
    assign dtr       = ctl.dtr;
    assign rts       = ctl.rts;
    assign sec_txd   = ctl.stx;
    assign chg_flag  = flag;
    assign irq       = flag & ctl.ie;

    generate
        if (FBUSY_STRAP) begin : g_fb
            assign fbusy = ctl.rts;
        end else begin : g_nofb
            assign fbusy = 1'b0;
        end
    endgenerate

    assert_ring_fall_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(lvl[LN_RING]) && $stable(lvl[N_LINES-1:1]) && !flag) |=> !flag);

    assert_ring_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(lvl[LN_RING]) |=> flag);

    assert_any_edge_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(lvl[N_LINES-1:1]) |=> flag);

    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> reg_rdata[B_IE]);

    assert_fb_R6: assert property (@(posedge clk) disable iff (rst)
        FBUSY_STRAP ? (fbusy == rts) : !fbusy);
endmodule

// File: tb/mdm_stat_ctrl_tb.sv
module mdm_stat_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  lines = 4'b0000;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, rdata_n;
    logic        dtr, rts, stx, fb, flag, irq;
    logic        dtr_n, rts_n, stx_n, fb_n, flag_n, irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mdm_stat_ctrl u_dut (
        .clk(clk), .rst(rst), .ring_i(lines[0]), .cts_i(lines[1]),
        .car_i(lines[2]), .srd_i(lines[3]), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rdata), .dtr(dtr), .rts(rts), .sec_txd(stx), .fbusy(fb),
        .chg_flag(flag), .irq(irq)
    );

    mdm_stat_ctrl #(.FBUSY_STRAP(1'b0)) u_dut_nostrap (
        .clk(clk), .rst(rst), .ring_i(lines[0]), .cts_i(lines[1]),
        .car_i(lines[2]), .srd_i(lines[3]), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rdata_n), .dtr(dtr_n), .rts(rts_n), .sec_txd(stx_n), .fbusy(fb_n),
        .chg_flag(flag_n), .irq(irq_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [15:0] d);
        wdata = d; wr = 1'b1;
        cyc(1);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [15:0] ctlw;
        // R9: reset with all lines high
        lines = 4'b1111;
        cyc(3);
        rst = 1'b0;
        cyc(6);
        chk("R9", "flag after reset with lines high", flag, 0);
        chk("R9", "control bits after reset", {dtr, rts, stx, rdata[5]}, 0);
        chk("R1", "status readback all high", rdata[11:8], 15);
        lines = 4'b0000;
        cyc(4);
        chk("R1", "status readback all low", rdata[11:8], 0);
        chk("R3", "flag after lines fell", flag, 1);

        // R5 / R6 / R4: sweep of control bits (flag set at this point)
        for (int v = 0; v < 16; v++) begin
            ctlw = '0;
            ctlw[1] = v[0]; ctlw[2] = v[1]; ctlw[3] = v[2]; ctlw[5] = v[3];
            do_write(ctlw);
            chk("R5", "dtr", dtr, v[0]);
            chk("R5", "rts", rts, v[1]);
            chk("R5", "sec_txd", stx, v[2]);
            chk("R5", "readback ctl bits", {rdata[5], rdata[3:1]}, v);
            chk("R6", "fbusy strapped", fb, v[1]);
            chk("R6", "fbusy unstrapped", fb_n, 0);
            chk("R7", "write bit7=0 keeps flag", flag, 1);
            chk("R4", "irq with flag set", irq, v[3]);
        end

        // R2 / R3 / R4: every line, both directions, enable on and off
        for (int ie = 0; ie < 2; ie++) begin
            for (int ln = 0; ln < 4; ln++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    ctlw = '0; ctlw[5] = ie[0]; ctlw[7] = 1'b1;
                    do_write(ctlw);
                    chk("R7", "flag cleared by write bit7=1", flag, 0);
                    chk("R4", "irq with flag clear", irq, 0);
                    lines[ln] = (dir == 0);
                    cyc(2);
                    chk("R1", "status bit after two edges", rdata[8+ln], (dir == 0));
                    cyc(1);
                    if (ln == 0) begin
                        chk(dir == 0 ? "R2" : "R2", "ring edge flag", flag, (dir == 0));
                    end else begin
                        chk("R3", "other line edge flag", flag, 1);
                    end
                    chk("R4", "irq follows flag and enable",
                        irq, ie & ((ln != 0) || (dir == 0)));
                    cyc(2);
                end
            end
        end

        // R8: clearing write in the same cycle as a line event
        lines[1] = 1'b1;
        cyc(4);
        chk("R8", "flag set before collision", flag, 1);
        lines[2] = 1'b1;
        cyc(2);
        wdata = 16'h0080; wr = 1'b1;
        cyc(1);
        wr = 1'b0; wdata = '0;
        chk("R8", "flag kept on event with clear", flag, 1);
        do_write(16'h0080);
        chk("R7", "flag cleared after collision", flag, 0);
        chk("R8", "unstrapped instance flag also clear", flag_n, 0);

        done = 1'b1;
        report();
    end
endmodule